// File: doc/BRIEF.md
# PHY Management Frame Register Bridge

This block lets software run a complete PHY management transaction with one 32-bit register write. The written word holds the whole management frame: start code, opcode, PHY address, register address, turnaround and data. The bridge decodes the frame in the same cycle. If the frame is valid it reads or writes an internal file of thirty-two 16-bit PHY registers. It then stores the frame with the low turnaround bit set, which marks the transaction as complete. No serial pin timing is involved, and any frame can be read back on the next cycle.

The PHY register file models basic control, status and auto-negotiation behaviour. Writes to the control register have self-clearing side effects. A link-up input sets or clears the status and partner-ability bits. A separate configuration register holds two read-only transceiver-present flags.

The bus is a single-cycle register port. Word offset 0 is the frame register and word offset 1 is the configuration register. Read data is combinational, and any other offset reads as zero.

Top module: `mii_mgmt_bridge`

## Requirements
- R1: After reset the frame register reads 0x00000000 and the configuration register reads 0x00000100.
- R2: The frame fields are start [31:30], opcode [29:28], PHY address [27:23], register [22:18], turnaround [17:16] and data [15:0]. A frame with start 01, PHY address 1 and opcode 01 writes the data field into the addressed PHY register. The stored frame is the written word with bit 16 set.
- R3: A valid frame with opcode 10 stores the written word with bit 16 set and the data field replaced by the addressed register's value.
- R4: A frame whose start code is not 01 changes no PHY register and is stored with bit 16 set.
- R5: A frame whose PHY address is not 1 changes no PHY register and is stored with bit 16 set.
- R6: A valid frame with opcode 00 or 11 changes no PHY register and is stored with bit 16 set, with its data field unchanged.
- R7: Writing register 0 with bit 15 (reset) set stores the value with bit 15 cleared and bit 12 (auto-negotiation enable) set.
- R8: Writing register 0 with bit 9 (restart) set stores the value with bit 9 cleared and sets bit 5 of register 1. If link_up_i is high, it also sets bit 2 of register 1 and bit 8 of register 5.
- R9: After reset, register 4 is 0x0100 and register 1 has bits 14, 5 and 3 set. One clock after reset, if link_up_i is high, register 1 bit 2 and register 5 bit 8 are also set.
- R10: A falling edge of link_up_i clears register 1 bit 2 and register 5 bit 8, and a rising edge sets them. Both take effect at the next clock.
- R11: Configuration bits 9:8 ignore writes; the other bits store the written value.
- R12: Read data for offsets 0 and 1 is valid in the cycle the read is presented, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| link_up_i | input | 1 | Link status from the line side |

## Verification
The bench goes after frames that must be rejected: a wrong start code, a wrong PHY address, and the two opcodes that do nothing. A bridge that only checked one of the fields would overwrite the scratch register the bench later reads back. The bench also drives the control register self-clears. A design that stored the raw word would return the reset or restart bits, or would miss the completion bit in register 1. Restart is run both with the link up and with it down, which catches a design that sets link status unconditionally. Finally, the bench writes all ones to the configuration register, which exposes a design that lets the read-only presence bits change.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  localparam int unsigned BUS_AW    = 4;
  localparam int unsigned BUS_DW    = 32;
  localparam int unsigned PHY_DW    = 16;
  localparam int unsigned PHY_AW    = 5;
  localparam int unsigned PHY_NREG  = 1 << PHY_AW;
  localparam logic [BUS_AW-1:0] OFF_FRAME = 4'd0;
  localparam logic [BUS_AW-1:0] OFF_CFG   = 4'd1;

  localparam logic [1:0] ST_OK  = 2'b01;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam int unsigned TA_DONE_BIT = 16;

  // register indices and bits
  localparam int unsigned R_CTRL = 0;
  localparam int unsigned R_STAT = 1;
  localparam int unsigned R_ADV  = 4;
  localparam int unsigned R_LPA  = 5;
  localparam int unsigned CTRL_RST   = 15;
  localparam int unsigned CTRL_ANEN  = 12;
  localparam int unsigned CTRL_ANRS  = 9;
  localparam int unsigned STAT_ANOK  = 5;
  localparam int unsigned STAT_LINK  = 2;
  localparam int unsigned LPA_TXFD   = 8;

  localparam logic [9:0] CFG_RO_MASK  = 10'h300;
  localparam logic [BUS_DW-1:0] CFG_RESET = 32'h0000_0100;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  reg_a;
    logic [1:0]  ta;
    logic [15:0] data;
  } frame_t;

  function automatic logic [PHY_DW-1:0] phy_rst_val(input int unsigned idx);
    case (idx)
      R_STAT:  phy_rst_val = 16'h4028; // 100TX-FD, AN done, AN able
      R_ADV:   phy_rst_val = 16'h0100; // advertise 100TX-FD
      default: phy_rst_val = '0;
    endcase
  endfunction
endpackage

// File: rtl/mgmt_frame_decode.sv
`timescale 1ns/1ps
module mgmt_frame_decode
  import mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic [BUS_DW-1:0] frame_i,
  output logic              hit_o,
  output logic              is_wr_o,
  output logic              is_rd_o,
  output logic [PHY_AW-1:0] reg_o
);
  frame_t f;
  assign f       = frame_t'(frame_i);
  assign hit_o   = (f.st == ST_OK) && (f.phy == PHY_ADDR);
  assign is_wr_o = hit_o && (f.op == OP_WR);
  assign is_rd_o = hit_o && (f.op == OP_RD);
  assign reg_o   = f.reg_a;
endmodule

// File: rtl/mii_phy_regfile.sv
`timescale 1ns/1ps
module mii_phy_regfile
  import mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PHY_AW-1:0] addr_i,
  input  logic [PHY_DW-1:0] wr_data_i,
  output logic [PHY_DW-1:0] rd_data_o,
  input  logic              link_up_i,
  output logic [PHY_DW-1:0] ctrl_o,
  output logic [PHY_DW-1:0] stat_o,
  output logic [PHY_DW-1:0] lpa_o
);
  logic [PHY_DW-1:0] regs_q [PHY_NREG];
  logic [PHY_DW-1:0] regs_d [PHY_NREG];
  logic              link_q;
  logic [PHY_DW-1:0] wv;

  assign rd_data_o = regs_q[addr_i];
  assign ctrl_o    = regs_q[R_CTRL];
  assign stat_o    = regs_q[R_STAT];
  assign lpa_o     = regs_q[R_LPA];

  always_comb begin
    regs_d = regs_q;
    wv     = wr_data_i;
    if (wr_en_i) begin
      if (addr_i == PHY_AW'(R_CTRL)) begin
        if (wv[CTRL_RST]) begin
          wv[CTRL_RST]  = 1'b0;
          wv[CTRL_ANEN] = 1'b1;
        end
        if (wv[CTRL_ANRS]) begin
          wv[CTRL_ANRS] = 1'b0;
          regs_d[R_STAT][STAT_ANOK] = 1'b1;
          if (link_up_i) begin
            regs_d[R_STAT][STAT_LINK] = 1'b1;
            regs_d[R_LPA][LPA_TXFD]   = 1'b1;
          end
        end
      end
      regs_d[addr_i] = wv;
    end
    // link edges override same-cycle writes
    if (link_up_i != link_q) begin
      regs_d[R_STAT][STAT_LINK] = link_up_i;
      regs_d[R_LPA][LPA_TXFD]   = link_up_i;
    end
  end

  for (genvar g = 0; g < PHY_NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= phy_rst_val(g);
      else         regs_q[g] <= regs_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b0;
    else         link_q <= link_up_i;
  end
endmodule

// File: rtl/mii_mgmt_bridge.sv
`timescale 1ns/1ps
module mii_mgmt_bridge
  import mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              link_up_i
);
  logic [BUS_DW-1:0] frame_q, frame_d, cfg_q;
  logic              frame_wr, cfg_wr;
  logic              hit, is_wr, is_rd;
  logic [PHY_AW-1:0] reg_a;
  logic [PHY_DW-1:0] phy_rd, ctrl_v, stat_v, lpa_v;

  assign frame_wr = bus_en_i && bus_we_i && (bus_addr_i == OFF_FRAME);
  assign cfg_wr   = bus_en_i && bus_we_i && (bus_addr_i == OFF_CFG);

  mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .frame_i (bus_wdata_i),
    .hit_o   (hit),
    .is_wr_o (is_wr),
    .is_rd_o (is_rd),
    .reg_o   (reg_a)
  );

  mii_phy_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (frame_wr && is_wr),
    .addr_i    (reg_a),
    .wr_data_i (bus_wdata_i[PHY_DW-1:0]),
    .rd_data_o (phy_rd),
    .link_up_i (link_up_i),
    .ctrl_o    (ctrl_v),
    .stat_o    (stat_v),
    .lpa_o     (lpa_v)
  );

  always_comb begin
    frame_d = bus_wdata_i;
    frame_d[TA_DONE_BIT] = 1'b1;
    if (is_rd) frame_d[PHY_DW-1:0] = phy_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frame_q <= '0;
    else if (frame_wr) frame_q <= frame_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_RESET;
    else if (cfg_wr) cfg_q <= (bus_wdata_i & ~BUS_DW'(CFG_RO_MASK))
                            | (cfg_q & BUS_DW'(CFG_RO_MASK));
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i) begin
      case (bus_addr_i)
        OFF_FRAME: bus_rdata_o = frame_q;
        OFF_CFG:   bus_rdata_o = cfg_q;
        default:   bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mii_mgmt_bridge_chk.sv
`timescale 1ns/1ps
module mii_mgmt_bridge_chk
  import mgmt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic [BUS_DW-1:0] bus_wdata_i,
  input logic              link_up_i,
  input logic [BUS_DW-1:0] frame_q,
  input logic [BUS_DW-1:0] cfg_q,
  input logic [PHY_DW-1:0] ctrl_v,
  input logic [PHY_DW-1:0] stat_v,
  input logic [PHY_DW-1:0] lpa_v
);
  logic fw;
  assign fw = bus_en_i && bus_we_i && (bus_addr_i == OFF_FRAME);

  p_done_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw |=> frame_q[TA_DONE_BIT]);

  p_bad_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw && bus_wdata_i[31:30] != ST_OK) |=> $stable(ctrl_v));

  p_bad_phy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw && bus_wdata_i[27:23] != 5'd1) |=> $stable(ctrl_v));

  p_ctrl_selfclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_v[CTRL_RST] && !ctrl_v[CTRL_ANRS]);

  p_link_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_up_i) |=> (!stat_v[STAT_LINK] && !lpa_v[LPA_TXFD]));

  p_cfg_ro_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[9:8] == 2'b01);
endmodule

bind mii_mgmt_bridge mii_mgmt_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .link_up_i   (link_up_i),
  .frame_q     (frame_q),
  .cfg_q       (cfg_q),
  .ctrl_v      (ctrl_v),
  .stat_v      (stat_v),
  .lpa_v       (lpa_v)
);

// File: tb/mii_mgmt_bridge_tb_top.sv
`timescale 1ns/1ps
module mii_mgmt_bridge_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_en_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        link_up_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mii_mgmt_bridge dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .link_up_i(link_up_i)
  );

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {st, op, phy, ra, 2'b00, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk_i);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 v = bus_rdata_o;
    bus_en_i = 0;
  endtask

  task automatic phy_wr(input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] v;
    wr(4'd0, mk(2'b01, 2'b01, 5'd1, ra, d));
    rd(4'd0, v);
    chk(v == (mk(2'b01, 2'b01, 5'd1, ra, d) | 32'h10000), "R2 write frame readback",
        v, mk(2'b01, 2'b01, 5'd1, ra, d) | 32'h10000);
  endtask

  task automatic phy_rd(input logic [4:0] ra, output logic [15:0] d);
    logic [31:0] v;
    wr(4'd0, mk(2'b01, 2'b10, 5'd1, ra, 16'hAAAA));
    rd(4'd0, v);
    chk(v[31:16] == (mk(2'b01, 2'b10, 5'd1, ra, 0) >> 16 | 32'h1), "R3 read frame header",
        v, {mk(2'b01, 2'b10, 5'd1, ra, 0) >> 16 | 32'h1, 16'h0});
    d = v[15:0];
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [15:0] d;
    rd(4'd0, v); chk(v == 32'h0, "R1 frame reset", v, 32'h0);
    rd(4'd1, v); chk(v == 32'h100, "R1 cfg reset", v, 32'h100);
    rd(4'd7, v); chk(v == 32'h0, "R12 unmapped read", v, 32'h0);
    phy_rd(5'd1, d); chk(d == 16'h402C, "R9 status reset with link", d, 16'h402C);
    phy_rd(5'd4, d); chk(d == 16'h0100, "R9 advert reset", d, 16'h0100);
    phy_rd(5'd5, d); chk(d == 16'h0100, "R9 partner reset with link", d, 16'h0100);
  endtask

  task automatic t_rw;
    logic [15:0] d;
    phy_wr(5'd7, 16'hBEEF);
    phy_rd(5'd7, d); chk(d == 16'hBEEF, "R2 write then read", d, 16'hBEEF);
    phy_wr(5'd31, 16'h0F0F);
    phy_rd(5'd31, d); chk(d == 16'h0F0F, "R3 read top register", d, 16'h0F0F);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    logic [15:0] d;
    wr(4'd0, mk(2'b00, 2'b01, 5'd1, 5'd7, 16'h1234));
    rd(4'd0, v); chk(v == (mk(2'b00, 2'b01, 5'd1, 5'd7, 16'h1234) | 32'h10000),
                     "R4 bad start stored", v, mk(2'b00, 2'b01, 5'd1, 5'd7, 16'h1234) | 32'h10000);
    phy_rd(5'd7, d); chk(d == 16'hBEEF, "R4 bad start no write", d, 16'hBEEF);
    wr(4'd0, mk(2'b01, 2'b01, 5'd2, 5'd7, 16'h5678));
    rd(4'd0, v); chk(v == (mk(2'b01, 2'b01, 5'd2, 5'd7, 16'h5678) | 32'h10000),
                     "R5 wrong phy stored", v, mk(2'b01, 2'b01, 5'd2, 5'd7, 16'h5678) | 32'h10000);
    phy_rd(5'd7, d); chk(d == 16'hBEEF, "R5 wrong phy no write", d, 16'hBEEF);
    wr(4'd0, mk(2'b01, 2'b10, 5'd0, 5'd7, 16'h4321));
    rd(4'd0, v); chk(v[15:0] == 16'h4321, "R5 wrong phy read keeps data", v, 32'h4321);
    for (int op = 0; op < 4; op += 3) begin
      wr(4'd0, mk(2'b01, 2'(op), 5'd1, 5'd7, 16'h9999));
      rd(4'd0, v); chk(v == (mk(2'b01, 2'(op), 5'd1, 5'd7, 16'h9999) | 32'h10000),
                       "R6 idle opcode stored", v, mk(2'b01, 2'(op), 5'd1, 5'd7, 16'h9999) | 32'h10000);
      phy_rd(5'd7, d); chk(d == 16'hBEEF, "R6 idle opcode no write", d, 16'hBEEF);
    end
  endtask

  task automatic t_ctrl;
    logic [15:0] d;
    phy_wr(5'd0, 16'h8000);
    phy_rd(5'd0, d); chk(d == 16'h1000, "R7 reset self-clear", d, 16'h1000);
    phy_wr(5'd1, 16'h0); phy_wr(5'd5, 16'h0);
    phy_wr(5'd0, 16'h0200);
    phy_rd(5'd0, d); chk(d == 16'h0000, "R8 restart self-clear", d, 16'h0000);
    phy_rd(5'd1, d); chk(d == 16'h0024, "R8 restart link up status", d, 16'h0024);
    phy_rd(5'd5, d); chk(d == 16'h0100, "R8 restart link up partner", d, 16'h0100);
    @(negedge clk_i) link_up_i = 0;
    repeat (2) @(negedge clk_i);
    phy_wr(5'd1, 16'h0); phy_wr(5'd5, 16'h0);
    phy_wr(5'd0, 16'h0200);
    phy_rd(5'd1, d); chk(d == 16'h0020, "R8 restart link down status", d, 16'h0020);
    phy_rd(5'd5, d); chk(d == 16'h0000, "R8 restart link down partner", d, 16'h0000);
  endtask

  task automatic t_link;
    logic [15:0] d;
    phy_wr(5'd1, 16'h4028);
    @(negedge clk_i) link_up_i = 1;
    repeat (2) @(negedge clk_i);
    phy_rd(5'd1, d); chk(d == 16'h402C, "R10 link rise status", d, 16'h402C);
    phy_rd(5'd5, d); chk(d == 16'h0100, "R10 link rise partner", d, 16'h0100);
    @(negedge clk_i) link_up_i = 0;
    repeat (2) @(negedge clk_i);
    phy_rd(5'd1, d); chk(d == 16'h4028, "R10 link fall status", d, 16'h4028);
    phy_rd(5'd5, d); chk(d == 16'h0000, "R10 link fall partner", d, 16'h0000);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v); chk(v == 32'hFFFF_FDFF, "R11 cfg ones", v, 32'hFFFF_FDFF);
    wr(4'd1, 32'h0);
    rd(4'd1, v); chk(v == 32'h0000_0100, "R11 cfg zeros", v, 32'h0000_0100);
    @(negedge clk_i);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = 4'd1;
    #1 chk(bus_rdata_o == 32'h100, "R12 same-cycle read", bus_rdata_o, 32'h100);
    bus_en_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_rw();
    t_reject();
    t_ctrl();
    t_link();
    t_cfg();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule